// File: doc/BRIEF.md
# H-Bridge Gate Control and Fault Supervisor

This block is the digital core of a full-bridge DC motor driver. Two direction inputs choose one of four bridge states: forward, reverse, brake on both low switches, or every switch open. The block turns that choice into enables for four power switches, with a high and a low switch on each of two output legs. Each enable waits for the opposite switch on its leg to report that it has stopped conducting, so a leg never conducts from supply straight to ground.

Fault comparators sit outside the block and feed it one bit per fault class: output short to ground or to supply, low-side overcurrent, open load, load short across the two outputs, overtemperature and supply undervoltage. A short, overcurrent, open-load or load-short indication must hold for a set number of clocks before the block acts on it. Once it does, the fault is latched, every switch is forced off and the active-low error flag is pulled down. How a latched fault is released depends on its class. Short, overcurrent and open-load faults clear when the direction inputs move to a state in which that fault cannot be seen. A load short clears only on reset. Overtemperature releases as soon as its comparator drops. Undervoltage is never latched.

The error flag stands for an open-drain pin. `err_drv` is the pull-down enable and `err_n` is the resulting level.

Top module: `hb_supervisor`

## Requirements
- R1: Direction decode, with gate_en bit 0 = leg A high, bit 1 = leg A low, bit 2 = leg B high, bit 3 = leg B low. Inputs {ctl_a,ctl_b}=00 enable 4'b1001, 01 enable 4'b0110 and 10 enable 4'b1010. An input change reaches gate_en one clock edge after it is sampled.
- R2: With {ctl_a,ctl_b}=11 all four enables are low. This is the high-impedance state, and it does not by itself raise the error flag.
- R3: A switch's enable is held low in the same cycle that the other switch on its leg reports conducting on cond_fb (same bit layout as gate_en). The two enables of a leg are never high together.
- R4: Ground short, supply short and low-side overcurrent share one class. That class is watched only in states other than 11. It latches on the QUAL_CYCLES-th consecutive clock edge at which one of its bits is sampled high. Any sample low restarts the count.
- R5: While any fault is latched, or undervoltage is present, gate_en is 4'b0000, err_drv is 1 and err_n is 0. With none of these present, err_drv is 0 and err_n is 1.
- R6: An open-load fault is watched only in state 11, and only when flt_open_hi and flt_open_lo are both high. It qualifies over the same QUAL_CYCLES window as R4.
- R7: A latched short/overcurrent or open-load fault clears on the clock edge after the sampled inputs change, provided that class's comparator is inactive in the new state. Without an input change it stays latched even when the comparator has dropped.
- R8: A latched load-short fault (flt_load_short, watched outside state 11) is not cleared by any input change. Only reset clears it.
- R9: Overtemperature (flt_overtemp, watched in every state) latches after QUAL_CYCLES consecutive high samples. Input changes leave it latched. It releases at the first edge at which its comparator is sampled low.
- R10: flt_uvlo is registered once. One edge after it is sampled high, all enables are low and the flag is low. One edge after it is sampled low, normal decode returns. Nothing is latched.
- R11: During reset, and until the first input sample after reset, all enables are low and the flag is released (err_n=1, err_drv=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_a | input | 1 | Direction input, first bit |
| ctl_b | input | 1 | Direction input, second bit |
| cond_fb | input | 4 | Per-switch conducting feedback, same layout as gate_en |
| flt_gnd_short | input | 1 | Output shorted to ground comparator |
| flt_vs_short | input | 1 | Output shorted to supply comparator |
| flt_overload | input | 1 | Low-side overcurrent comparator |
| flt_open_hi | input | 1 | Leg A output near supply while bridge is open |
| flt_open_lo | input | 1 | Leg B output near ground while bridge is open |
| flt_load_short | input | 1 | Short between the two outputs |
| flt_overtemp | input | 1 | Overtemperature comparator (hysteresis external) |
| flt_uvlo | input | 1 | Undervoltage lockout active |
| gate_en | output | 4 | Switch enables: A high, A low, B high, B low |
| err_n | output | 1 | Error flag level, active low |
| err_drv | output | 1 | Open-drain pull-down enable for the error flag |

## Verification
The decode is exercised in all four input states, and then with conducting feedback raised on one switch of each leg. Together these separate a wrong mapping from a missing interlock. Fault stimulus covers pulses one sample short of the window, a restarted window, and a full window, which pins the exact latch edge. Release behaviour is probed by moving to states where a fault stays visible and where it vanishes, by dropping a comparator with no input change, and by toggling after a load short and an overtemperature. This tells the three release policies apart. A behavioural model is compared against every output on each clock.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    MODE_FWD   = 2'b00,
    MODE_REV   = 2'b01,
    MODE_BRAKE = 2'b10,
    MODE_HIZ   = 2'b11
  } hb_mode_e;

  typedef enum logic [1:0] {
    CLR_ON_TOGGLE,
    CLR_NEVER,
    CLR_ON_RELEASE
  } clr_pol_e;

  localparam int SW_A_HI = 0;
  localparam int SW_A_LO = 1;
  localparam int SW_B_HI = 2;
  localparam int SW_B_LO = 3;
  localparam int NSW     = 4;
  localparam int NLEG    = 2;

  localparam int CAT_SHORT = 0;
  localparam int CAT_OPEN  = 1;
  localparam int CAT_LOAD  = 2;
  localparam int CAT_HEAT  = 3;
  localparam int NCAT      = 4;

  // switches requested by a bridge state, before interlock and kill
  function automatic logic [NSW-1:0] mode_demand(hb_mode_e m);
    logic [NSW-1:0] d;
    d = '0;
    unique case (m)
      MODE_FWD:   begin d[SW_A_HI] = 1'b1; d[SW_B_LO] = 1'b1; end
      MODE_REV:   begin d[SW_A_LO] = 1'b1; d[SW_B_HI] = 1'b1; end
      MODE_BRAKE: begin d[SW_A_LO] = 1'b1; d[SW_B_LO] = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction

  // how each fault class leaves its latch
  function automatic clr_pol_e cat_policy(int c);
    if (c == CAT_LOAD) return CLR_NEVER;
    if (c == CAT_HEAT) return CLR_ON_RELEASE;
    return CLR_ON_TOGGLE;
  endfunction

  // next value of a saturating persistence counter
  function automatic int unsigned persist_next(logic raw, int unsigned cnt, int unsigned lim);
    if (!raw) return 0;
    if (cnt >= lim) return lim;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/hb_in_sample.sv
module hb_in_sample
  import hb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_a,
  input  logic     ctl_b,
  output hb_mode_e mode,
  output logic     valid,
  output logic     changed
);

  logic [1:0] in_q;
  logic [1:0] in_prev;
  logic       vld_q;
  logic       vld_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q     <= 2'b00;
      in_prev  <= 2'b00;
      vld_q    <= 1'b0;
      vld_prev <= 1'b0;
    end else begin
      in_q     <= {ctl_a, ctl_b};
      in_prev  <= in_q;
      vld_q    <= 1'b1;
      vld_prev <= vld_q;
    end
  end

  assign mode    = hb_mode_e'(in_q);
  assign valid   = vld_q;
  // a change is only meaningful once two real samples exist
  assign changed = vld_prev && (in_q != in_prev);

endmodule

// File: rtl/hb_fault_qual.sv
module hb_fault_qual #(
  parameter int QUAL_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);

  localparam int LIM = QUAL_CYCLES - 1;
  localparam int CW  = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= CW'(hb_pkg::persist_next(raw, int'(cnt), LIM));
    end
  end

  // this sample is the QUAL_CYCLES-th consecutive high one
  assign qual = raw && (cnt >= CW'(LIM));

endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch
  import hb_pkg::*;
#(
  parameter clr_pol_e POL = CLR_ON_TOGGLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic raw,
  input  logic changed,
  output logic lat
);

  logic clr;

  generate
    if (POL == CLR_ON_TOGGLE) begin : g_toggle
      assign clr = changed && !raw;
    end else if (POL == CLR_ON_RELEASE) begin : g_release
      assign clr = !raw;
    end else begin : g_never
      assign clr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lat <= 1'b0;
    else if (set) lat <= 1'b1;
    else if (clr) lat <= 1'b0;
  end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
(
  input  hb_mode_e       mode,
  input  logic           kill,
  input  logic [NSW-1:0] cond_fb,
  output logic [NSW-1:0] gate_en
);

  logic [NSW-1:0] demand;

  assign demand = mode_demand(mode);

  generate
    for (genvar l = 0; l < NLEG; l++) begin : g_leg
      localparam int HI = 2 * l;
      localparam int LO = 2 * l + 1;
      // each side waits for its partner to stop conducting
      assign gate_en[HI] = demand[HI] && !kill && !cond_fb[LO];
      assign gate_en[LO] = demand[LO] && !kill && !cond_fb[HI];
    end
  endgenerate

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
  import hb_pkg::*;
#(
  parameter int QUAL_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_a,
  input  logic       ctl_b,
  input  logic [3:0] cond_fb,
  input  logic       flt_gnd_short,
  input  logic       flt_vs_short,
  input  logic       flt_overload,
  input  logic       flt_open_hi,
  input  logic       flt_open_lo,
  input  logic       flt_load_short,
  input  logic       flt_overtemp,
  input  logic       flt_uvlo,
  output logic [3:0] gate_en,
  output logic       err_n,
  output logic       err_drv
);

  hb_mode_e        mode;
  logic            in_valid;
  logic            in_changed;
  logic            hiz;
  logic            uv_q;
  logic [NCAT-1:0] raw_vec;
  logic [NCAT-1:0] qual_vec;
  logic [NCAT-1:0] lat_vec;
  logic            kill;

  hb_in_sample u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_a   (ctl_a),
    .ctl_b   (ctl_b),
    .mode    (mode),
    .valid   (in_valid),
    .changed (in_changed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_q <= 1'b0;
    else        uv_q <= flt_uvlo;
  end

  assign hiz = (mode == MODE_HIZ);

  // per-class visibility in the present bridge state
  assign raw_vec[CAT_SHORT] = in_valid && !hiz && (flt_gnd_short || flt_vs_short || flt_overload);
  assign raw_vec[CAT_OPEN]  = in_valid &&  hiz && flt_open_hi && flt_open_lo;
  assign raw_vec[CAT_LOAD]  = in_valid && !hiz && flt_load_short;
  assign raw_vec[CAT_HEAT]  = flt_overtemp;

  generate
    for (genvar c = 0; c < NCAT; c++) begin : g_cat
      hb_fault_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_vec[c]),
        .qual  (qual_vec[c])
      );
      hb_fault_latch #(.POL(cat_policy(c))) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (qual_vec[c]),
        .raw     (raw_vec[c]),
        .changed (in_changed),
        .lat     (lat_vec[c])
      );
    end
  endgenerate

  assign err_drv = (|lat_vec) || uv_q;
  assign err_n   = !err_drv;
  assign kill    = err_drv || !in_valid;

  hb_gate_ctrl u_gate (
    .mode    (mode),
    .kill    (kill),
    .cond_fb (cond_fb),
    .gate_en (gate_en)
  );

endmodule

// File: rtl/hb_supervisor_chk.sv
module hb_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_a,
  input logic       ctl_b,
  input logic [3:0] cond_fb,
  input logic       flt_uvlo,
  input logic [3:0] gate_en,
  input logic       err_n,
  input logic       lat_short,
  input logic       raw_short,
  input logic       lat_load
);

  logic up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;
  end

  // R3
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en[0] && gate_en[1]));
  // R3
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en[2] && gate_en[3]));
  // R3
  a_hi_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_fb[1] |-> !gate_en[0]);
  // R3
  b_lo_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_fb[2] |-> !gate_en[3]);
  // R5
  flag_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> (gate_en == 4'b0000));
  // R2
  hiz_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(ctl_a && ctl_b)) |-> (gate_en == 4'b0000));
  // R10
  uv_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(flt_uvlo)) |-> (!err_n && gate_en == 4'b0000));
  // R4
  short_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $rose(lat_short)) |-> $past(raw_short));
  // R8
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> !$fell(lat_load));

endmodule

bind hb_supervisor hb_supervisor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_a     (ctl_a),
  .ctl_b     (ctl_b),
  .cond_fb   (cond_fb),
  .flt_uvlo  (flt_uvlo),
  .gate_en   (gate_en),
  .err_n     (err_n),
  .lat_short (lat_vec[hb_pkg::CAT_SHORT]),
  .raw_short (raw_vec[hb_pkg::CAT_SHORT]),
  .lat_load  (lat_vec[hb_pkg::CAT_LOAD])
);

// File: tb/hb_supervisor_tb_top.sv
module hb_supervisor_tb_top;

  localparam int QUAL = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_a, ctl_b;
  logic [3:0] cond_fb;
  logic       flt_gnd_short, flt_vs_short, flt_overload;
  logic       flt_open_hi, flt_open_lo, flt_load_short;
  logic       flt_overtemp, flt_uvlo;
  logic [3:0] gate_en;
  logic       err_n, err_drv;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R11";
  bit    done = 0;

  always #10 clk = ~clk;

  hb_supervisor #(.QUAL_CYCLES(QUAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_a(ctl_a), .ctl_b(ctl_b), .cond_fb(cond_fb),
    .flt_gnd_short(flt_gnd_short), .flt_vs_short(flt_vs_short),
    .flt_overload(flt_overload), .flt_open_hi(flt_open_hi),
    .flt_open_lo(flt_open_lo), .flt_load_short(flt_load_short),
    .flt_overtemp(flt_overtemp), .flt_uvlo(flt_uvlo),
    .gate_en(gate_en), .err_n(err_n), .err_drv(err_drv)
  );

  // ---------------- behavioural reference ----------------
  bit       m_vld, m_vld2, m_uv;
  bit [1:0] m_in, m_prev;
  int       m_cnt [4];
  bit       m_lat [4];
  bit       t_raw [4];
  bit       t_chg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_vld2 = 0; m_uv = 0; m_in = 0; m_prev = 0;
      for (int c = 0; c < 4; c++) begin m_cnt[c] = 0; m_lat[c] = 0; end
    end else begin
      t_raw[0] = m_vld && m_in != 2'b11 && (flt_gnd_short || flt_vs_short || flt_overload);
      t_raw[1] = m_vld && m_in == 2'b11 && flt_open_hi && flt_open_lo;
      t_raw[2] = m_vld && m_in != 2'b11 && flt_load_short;
      t_raw[3] = flt_overtemp;
      t_chg    = m_vld2 && (m_in != m_prev);
      for (int c = 0; c < 4; c++) begin
        if (t_raw[c] && m_cnt[c] + 1 >= QUAL) m_lat[c] = 1;
        else if (c == 3 && !t_raw[c]) m_lat[c] = 0;
        else if ((c == 0 || c == 1) && t_chg && !t_raw[c]) m_lat[c] = 0;
        m_cnt[c] = t_raw[c] ? ((m_cnt[c] + 1 >= QUAL) ? QUAL - 1 : m_cnt[c] + 1) : 0;
      end
      m_uv   = flt_uvlo;
      m_prev = m_in;
      m_in   = {ctl_a, ctl_b};
      m_vld2 = m_vld;
      m_vld  = 1;
    end
  end

  function automatic bit model_err();
    return m_lat[0] || m_lat[1] || m_lat[2] || m_lat[3] || m_uv;
  endfunction

  function automatic logic [3:0] model_gates();
    logic [3:0] g;
    if (!m_vld || model_err()) return 4'b0000;
    case (m_in)
      2'b00:   g = 4'b1001;
      2'b01:   g = 4'b0110;
      2'b10:   g = 4'b1010;
      default: g = 4'b0000;
    endcase
    if (cond_fb[1]) g[0] = 1'b0;
    if (cond_fb[0]) g[1] = 1'b0;
    if (cond_fb[3]) g[2] = 1'b0;
    if (cond_fb[2]) g[3] = 1'b0;
    return g;
  endfunction

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "model gate_en", gate_en, model_gates());
      check(cur_req, "model err_n", {3'b0, err_n}, {3'b0, !model_err()});
      check(cur_req, "model err_drv", {3'b0, err_drv}, {3'b0, model_err()});
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_in(logic [1:0] v);
    {ctl_a, ctl_b} = v;
  endtask

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; set_in(2'b00); cond_fb = 0;
    flt_gnd_short = 0; flt_vs_short = 0; flt_overload = 0;
    flt_open_hi = 0; flt_open_lo = 0; flt_load_short = 0;
    flt_overtemp = 0; flt_uvlo = 0;
    tick(2);
    // R11 reset state
    check("R11", "reset gate_en", gate_en, 4'b0000);
    check("R11", "reset err_n", {3'b0, err_n}, 4'b0001);
    check("R11", "reset err_drv", {3'b0, err_drv}, 4'b0000);
    rst_n = 1;
    cur_req = "R1";
    tick(1);
    check("R1", "forward", gate_en, 4'b1001);
    set_in(2'b01); tick(1);
    check("R1", "reverse", gate_en, 4'b0110);
    set_in(2'b10); tick(1);
    check("R1", "brake", gate_en, 4'b1010);
    cur_req = "R2";
    set_in(2'b11); tick(1);
    check("R2", "hiz gate_en", gate_en, 4'b0000);
    check("R2", "hiz err_n", {3'b0, err_n}, 4'b0001);

    // R3 interlock
    cur_req = "R3";
    set_in(2'b00); tick(1);
    cond_fb = 4'b0010; #1;
    check("R3", "A high waits for A low", gate_en, 4'b1000);
    cond_fb = 4'b0100; #1;
    check("R3", "B low waits for B high", gate_en, 4'b0001);
    cond_fb = 4'b0000; tick(1);

    // R4 qualification window with restart
    cur_req = "R4";
    flt_gnd_short = 1; tick(QUAL - 1);
    flt_gnd_short = 0; tick(1);
    flt_gnd_short = 1; tick(QUAL - 1);
    check("R4", "not yet qualified", {3'b0, err_n}, 4'b0001);
    tick(1);
    check("R4", "qualified", {3'b0, err_n}, 4'b0000);
    cur_req = "R5";
    check("R5", "fault gate_en", gate_en, 4'b0000);
    check("R5", "fault err_drv", {3'b0, err_drv}, 4'b0001);

    // R7 toggle clear
    cur_req = "R7";
    set_in(2'b01); tick(3);
    check("R7", "still visible in reverse", {3'b0, err_n}, 4'b0000);
    set_in(2'b11); tick(1);
    check("R7", "one edge after change", {3'b0, err_n}, 4'b0000);
    tick(1);
    check("R7", "cleared after change", {3'b0, err_n}, 4'b0001);
    flt_gnd_short = 0;
    set_in(2'b10); flt_overload = 1; tick(QUAL + 1);
    check("R7", "overload latched", {3'b0, err_n}, 4'b0000);
    flt_overload = 0; tick(3);
    check("R7", "no change no clear", {3'b0, err_n}, 4'b0000);
    set_in(2'b00); tick(2);
    check("R7", "cleared by change", gate_en, 4'b1001);

    // R6 open load
    cur_req = "R6";
    flt_open_hi = 1; flt_open_lo = 1; tick(QUAL + 3);
    check("R6", "ignored outside hiz", {3'b0, err_n}, 4'b0001);
    set_in(2'b11); tick(1);
    tick(QUAL - 1);
    check("R6", "open not yet qualified", {3'b0, err_n}, 4'b0001);
    tick(1);
    check("R6", "open latched", {3'b0, err_n}, 4'b0000);
    set_in(2'b00); tick(2);
    check("R6", "open cleared by leaving hiz", gate_en, 4'b1001);
    flt_open_hi = 1; flt_open_lo = 0; set_in(2'b11); tick(QUAL + 3);
    check("R6", "single comparator ignored", {3'b0, err_n}, 4'b0001);
    flt_open_hi = 0;

    // R8 load short
    cur_req = "R8";
    set_in(2'b00); tick(1);
    flt_load_short = 1; tick(QUAL + 1);
    check("R8", "load short latched", {3'b0, err_n}, 4'b0000);
    flt_load_short = 0;
    set_in(2'b01); tick(2); set_in(2'b11); tick(2); set_in(2'b00); tick(2);
    check("R8", "toggling keeps latch", {3'b0, err_n}, 4'b0000);
    check("R8", "toggling keeps off", gate_en, 4'b0000);
    rst_n = 0; tick(1);
    check("R8", "reset clears", {3'b0, err_n}, 4'b0001);
    rst_n = 1; tick(1);
    check("R8", "normal after reset", gate_en, 4'b1001);

    // R9 overtemperature
    cur_req = "R9";
    flt_overtemp = 1; tick(QUAL + 1);
    check("R9", "heat latched", {3'b0, err_n}, 4'b0000);
    set_in(2'b01); tick(3);
    check("R9", "toggle ignored", gate_en, 4'b0000);
    flt_overtemp = 0; tick(1);
    check("R9", "released flag", {3'b0, err_n}, 4'b0001);
    check("R9", "released gates", gate_en, 4'b0110);

    // R10 undervoltage
    cur_req = "R10";
    flt_uvlo = 1; tick(1);
    check("R10", "uv gates", gate_en, 4'b0000);
    check("R10", "uv flag", {3'b0, err_n}, 4'b0000);
    flt_uvlo = 0; tick(1);
    check("R10", "uv released", gate_en, 4'b0110);
    check("R10", "uv flag released", {3'b0, err_n}, 4'b0001);

    tick(3);
    summary();
  end

endmodule